// File: doc/BRIEF.md
# Per-Lane Event Edge Detector

This block watches a vector of single-bit event lines and reports, on each line, the transitions that line has been set up to look for. Each line (lane) has its own two-bit edge-kind field and its own report-enable bit. Each cycle the block outputs one detected-edge vector with one bit per lane. It also outputs a trigger. The trigger asserts when the low lanes of the raw event vector equal a programmed pattern on the bit positions that a programmed compare mask selects.

All settings arrive through one narrow write port. A write first loads a lane pointer. Later writes then set the edge kind or the report-enable bit of the lane that pointer selects. The pointer keeps its value until it is loaded again, so several value writes can follow one pointer write. The trigger pattern and the trigger compare mask are loaded through the same port with operation codes of their own. An event source usually drives `evt_i` every cycle, and a trace collector samples `edge_o` and `trig_o`.

Top module: `evt_edge_unit`

## Requirements
- R1: While reset is low, and on the first cycle after it, `edge_o` and `trig_o` are zero. Reset also sets the lane pointer to 0, every edge kind to code 00, every report-enable bit to 0, and the trigger pattern and trigger mask to zero.
- R2: Edge kind 00 (rising) sets `edge_o[i]` when lane i was 0 on one clock edge and is 1 on the next.
- R3: Edge kind 01 (falling) sets `edge_o[i]` when lane i was 1 on one clock edge and is 0 on the next.
- R4: Edge kind 10 (toggle) sets `edge_o[i]` on any change of lane i between two consecutive clock edges.
- R5: Edge kind 11 is reserved, and a lane with this kind never reports.
- R6: A lane whose report-enable bit is 0 never reports, whatever its edge kind.
- R7: A detection is registered. A change sampled at clock edge k shows on `edge_o` after edge k and stays high for exactly one cycle. An unchanged level reports nothing.
- R8: The first clock edge after reset is released only captures the inputs. A lane that is already high at that edge is not reported as rising.
- R9: A write takes effect when `cfg_we_i` is 1 at a clock edge. The operation is chosen by `cfg_op_i`:
  - 0 loads the lane pointer from `cfg_data_i[8:0]`.
  - 1 sets the edge kind of the selected lane from `cfg_data_i[1:0]`.
  - 2 sets its report-enable bit from `cfg_data_i[0]`.
  - 5 to 7 do nothing.
  The pointer holds until it is reloaded, and a value write made before any pointer write goes to lane 0. A new setting applies from the next clock edge on.
- R10: A value write whose lane pointer is LANES or greater changes no lane.
- R11: Operation 3 loads the trigger pattern, and operation 4 loads the trigger mask, each from `cfg_data_i[TRIG_W-1:0]`. A mask bit of 1 means that position is compared. `trig_o` goes high in the cycle after a clock edge at which `evt_i[TRIG_W-1:0]` equals the pattern on every compared position.
- R12: With a trigger mask of all zeros, `trig_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | LANES | Event lines, one per lane |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_op_i | input | 3 | Configuration operation code |
| cfg_data_i | input | 32 | Configuration write data |
| edge_o | output | LANES | Detected edges, one bit per lane |
| trig_o | output | 1 | Masked pattern-match trigger |

## Verification
Directed sequences drive isolated 0-to-1 and 1-to-0 steps on lanes that have each edge kind. These separate rising, falling, toggle and reserved codes, and they show that a disabled lane stays silent. Held levels and a reset released while lanes are high separate a true edge from a level. Out-of-range pointer writes and value writes made before any pointer write show which lane a write reaches. A long constrained-random run then mixes sparse bit flips with random configuration writes, including unused codes. It compares every output against a reference model, so a wrong lane, a wrong cycle or a wrong kind all show up as mismatches.

// File: rtl/evt_edge_pkg.sv
package evt_edge_pkg;

   localparam int MAX_LANES = 256;
   localparam int CFG_W     = 32;
   localparam int PTR_W     = 9;

   typedef enum logic [1:0] {
      EDGE_RISE = 2'b00,
      EDGE_FALL = 2'b01,
      EDGE_BOTH = 2'b10,
      EDGE_NONE = 2'b11
   } edge_kind_e;

   typedef enum logic [2:0] {
      OP_PTR  = 3'd0,
      OP_KIND = 3'd1,
      OP_EN   = 3'd2,
      OP_TPAT = 3'd3,
      OP_TMSK = 3'd4
   } cfg_op_e;

   // one-lane classification of a previous/current sample pair
   function automatic logic edge_hit(edge_kind_e kind, logic prv, logic cur);
      logic r;
      case (kind)
         EDGE_RISE: r = ~prv & cur;
         EDGE_FALL: r = prv & ~cur;
         EDGE_BOTH: r = prv ^ cur;
         default:   r = 1'b0;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/evt_cfg_bank.sv
module evt_cfg_bank
   import evt_edge_pkg::*;
#(
   parameter int LANES  = 64,
   parameter int TRIG_W = 32
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cfg_we_i,
   input  logic [2:0]                 cfg_op_i,
   input  logic [CFG_W-1:0]           cfg_data_i,
   output logic [LANES-1:0][1:0]      kind_o,
   output logic [LANES-1:0]           en_o,
   output logic [TRIG_W-1:0]          tpat_o,
   output logic [TRIG_W-1:0]          tmsk_o
);

   logic [PTR_W-1:0] ptr_q;
   logic             wr_kind, wr_en;

   assign wr_kind = cfg_we_i && (cfg_op_i == OP_KIND);
   assign wr_en   = cfg_we_i && (cfg_op_i == OP_EN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (cfg_we_i && cfg_op_i == OP_PTR) begin
         ptr_q <= cfg_data_i[PTR_W-1:0];
      end
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      localparam logic [PTR_W-1:0] LANE_ID = PTR_W'(g);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            kind_o[g] <= EDGE_RISE;
            en_o[g]   <= 1'b0;
         end else if (ptr_q == LANE_ID) begin
            if (wr_kind) kind_o[g] <= cfg_data_i[1:0];
            if (wr_en)   en_o[g]   <= cfg_data_i[0];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tpat_o <= '0;
         tmsk_o <= '0;
      end else if (cfg_we_i) begin
         if (cfg_op_i == OP_TPAT) tpat_o <= cfg_data_i[TRIG_W-1:0];
         if (cfg_op_i == OP_TMSK) tmsk_o <= cfg_data_i[TRIG_W-1:0];
      end
   end

   // R9: pointer holds between pointer writes
   a_r9_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_we_i && cfg_op_i == OP_PTR) |=> $stable(ptr_q));

   // R10: a pointer beyond the lane range reaches no lane
   a_r10_far_ptr: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(ptr_q) >= LANES) |=> ($stable(kind_o) && $stable(en_o)));

   // R9: lane settings move only on a write
   a_r9_no_write_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we_i |=> ($stable(kind_o) && $stable(en_o) && $stable(tmsk_o)));

endmodule

// File: rtl/evt_lane_det.sv
module evt_lane_det
   import evt_edge_pkg::*;
#(
   parameter int LANES = 64
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [LANES-1:0]      evt_i,
   input  logic [LANES-1:0][1:0] kind_i,
   input  logic [LANES-1:0]      en_i,
   output logic [LANES-1:0]      edge_o
);

   logic [LANES-1:0] prev_q;
   logic [LANES-1:0] hit;
   logic             primed_q;

   for (genvar g = 0; g < LANES; g++) begin : g_cls
      always_comb begin
         hit[g] = en_i[g] & edge_hit(edge_kind_e'(kind_i[g]), prev_q[g], evt_i[g]);
      end

      // R5: reserved kind never reports
      a_r5_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
         edge_o[g] |-> ($past(kind_i[g]) != 2'b11));

      // R6: disabled lane never reports
      a_r6_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
         edge_o[g] |-> $past(en_i[g]));

      // R7: a report needs a change of the input between the two samples
      a_r7_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
         edge_o[g] |-> ($past(evt_i[g]) != $past(prev_q[g])));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q   <= '0;
         primed_q <= 1'b0;
         edge_o   <= '0;
      end else begin
         prev_q   <= evt_i;
         primed_q <= 1'b1;
         edge_o   <= primed_q ? hit : '0;
      end
   end

   // R8: capture edge after reset produces no report
   a_r8_capture_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !primed_q |=> (edge_o == '0));

endmodule

// File: rtl/evt_trig_match.sv
module evt_trig_match #(
   parameter int TRIG_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TRIG_W-1:0] view_i,
   input  logic [TRIG_W-1:0] tpat_i,
   input  logic [TRIG_W-1:0] tmsk_i,
   output logic              trig_o
);

   logic match;

   assign match = (|tmsk_i) && (((view_i ^ tpat_i) & tmsk_i) == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) trig_o <= 1'b0;
      else        trig_o <= match;
   end

   // R12: an empty compare set never triggers
   a_r12_empty_mask: assert property (@(posedge clk) disable iff (!rst_n)
      trig_o |-> ($past(tmsk_i) != '0));

endmodule

// File: rtl/evt_edge_unit.sv
module evt_edge_unit
   import evt_edge_pkg::*;
#(
   parameter int LANES  = 64,
   parameter int TRIG_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LANES-1:0] evt_i,
   input  logic             cfg_we_i,
   input  logic [2:0]       cfg_op_i,
   input  logic [31:0]      cfg_data_i,
   output logic [LANES-1:0] edge_o,
   output logic             trig_o
);

   if (LANES < 1 || LANES > MAX_LANES) begin : g_bad_lanes
      $error("evt_edge_unit: LANES out of range 1..%0d", MAX_LANES);
   end
   if (TRIG_W < 1 || TRIG_W > CFG_W) begin : g_bad_trig
      $error("evt_edge_unit: TRIG_W out of range 1..%0d", CFG_W);
   end

   logic [LANES-1:0][1:0] kind;
   logic [LANES-1:0]      en;
   logic [TRIG_W-1:0]     tpat, tmsk, view;

   // trigger view: slice when wide enough, zero-extend otherwise
   if (LANES >= TRIG_W) begin : g_view_slice
      assign view = evt_i[TRIG_W-1:0];
   end else begin : g_view_pad
      assign view = {{(TRIG_W-LANES){1'b0}}, evt_i};
   end

   evt_cfg_bank #(.LANES(LANES), .TRIG_W(TRIG_W)) u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we_i   (cfg_we_i),
      .cfg_op_i   (cfg_op_i),
      .cfg_data_i (cfg_data_i),
      .kind_o     (kind),
      .en_o       (en),
      .tpat_o     (tpat),
      .tmsk_o     (tmsk)
   );

   evt_lane_det #(.LANES(LANES)) u_det (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt_i  (evt_i),
      .kind_i (kind),
      .en_i   (en),
      .edge_o (edge_o)
   );

   evt_trig_match #(.TRIG_W(TRIG_W)) u_trig (
      .clk    (clk),
      .rst_n  (rst_n),
      .view_i (view),
      .tpat_i (tpat),
      .tmsk_i (tmsk),
      .trig_o (trig_o)
   );

endmodule

// File: tb/evt_edge_unit_test.sv
`timescale 1ns/1ps
module evt_edge_unit_test;

   localparam int L  = 64;
   localparam int TW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [L-1:0]  evt = '0;
   logic          we = 1'b0;
   logic [2:0]    op = '0;
   logic [31:0]   dat = '0;
   logic [L-1:0]  edge_o;
   logic          trig_o;

   int total = 0;
   int bad   = 0;
   bit fin   = 0;

   // reference model state
   logic [1:0]    m_kind [L];
   logic [L-1:0]  m_en;
   logic [L-1:0]  m_prev;
   logic          m_primed;
   logic [8:0]    m_ptr;
   logic [TW-1:0] m_pat, m_msk;
   logic [L-1:0]  ev;

   always #2 clk = ~clk;

   evt_edge_unit #(.LANES(L), .TRIG_W(TW)) uut (
      .clk(clk), .rst_n(rst_n), .evt_i(evt), .cfg_we_i(we),
      .cfg_op_i(op), .cfg_data_i(dat), .edge_o(edge_o), .trig_o(trig_o)
   );

   function automatic logic [L-1:0] exp_edge(logic [L-1:0] cur);
      logic [L-1:0] r = '0;
      for (int i = 0; i < L; i++) begin
         if (m_primed && m_en[i]) begin
            case (m_kind[i])
               2'd0: r[i] = !m_prev[i] && cur[i];
               2'd1: r[i] = m_prev[i] && !cur[i];
               2'd2: r[i] = m_prev[i] != cur[i];
               default: r[i] = 1'b0;
            endcase
         end
      end
      return r;
   endfunction

   function automatic logic exp_trig(logic [L-1:0] cur);
      if (m_msk == '0) return 1'b0;
      return ((cur[TW-1:0] ^ m_pat) & m_msk) == '0;
   endfunction

   task automatic model_reset();
      for (int i = 0; i < L; i++) m_kind[i] = 2'd0;
      m_en = '0; m_prev = '0; m_primed = 0; m_ptr = '0; m_pat = '0; m_msk = '0;
   endtask

   task automatic check(input string tag, input string what,
                        input logic [L-1:0] act, input logic [L-1:0] expv);
      total++;
      if (act !== expv) begin
         bad++;
         $display("FAIL %s %s act=%h exp=%h", tag, what, act, expv);
      end
   endtask

   // one clock: drive at the falling edge, predict, check at the next falling edge
   task automatic cyc(input logic [L-1:0] e, input logic w, input logic [2:0] o,
                      input logic [31:0] d, input string tag);
      logic [L-1:0] xe;
      logic         xt;
      evt = e; we = w; op = o; dat = d;
      xe = exp_edge(e);
      xt = exp_trig(e);
      m_prev = e; m_primed = 1;
      if (w) begin
         case (o)
            3'd0: m_ptr = d[8:0];
            3'd1: if (m_ptr < L) m_kind[m_ptr] = d[1:0];
            3'd2: if (m_ptr < L) m_en[m_ptr] = d[0];
            3'd3: m_pat = d[TW-1:0];
            3'd4: m_msk = d[TW-1:0];
            default: ;
         endcase
      end
      @(posedge clk); @(negedge clk);
      we = 1'b0;
      check(tag, "edge", edge_o, xe);
      check(tag, "trig", {{(L-1){1'b0}}, trig_o}, {{(L-1){1'b0}}, xt});
   endtask

   task automatic idle(input int n, input string tag);
      for (int k = 0; k < n; k++) cyc(ev, 0, 3'd0, 0, tag);
   endtask

   task automatic wr(input logic [2:0] o, input logic [31:0] d, input string tag);
      cyc(ev, 1, o, d, tag);
   endtask

   task automatic set_lane(input int lane, input int kind, input int en, input string tag);
      wr(3'd0, lane, tag);
      wr(3'd1, kind, tag);
      wr(3'd2, en, tag);
   endtask

   task automatic do_reset(input logic [L-1:0] e);
      @(negedge clk);
      rst_n = 1'b0; evt = e; we = 0; ev = e;
      #1;
      check("R1", "edge in reset", edge_o, '0);
      check("R1", "trig in reset", {{(L-1){1'b0}}, trig_o}, '0);
      model_reset();
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #(4 * 150000);
      if (!fin) begin
         bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      model_reset();
      // R1 / R8: reset released with every lane high
      do_reset('1);
      cyc(ev, 0, 0, 0, "R8");
      idle(2, "R1");

      // R9: value write before any pointer write goes to lane 0
      ev = '0;
      cyc(ev, 1, 3'd2, 32'h1, "R9");
      ev[0] = 1'b1; idle(1, "R9");
      ev[0] = 1'b0; idle(1, "R9");

      // R2 rising on lane 5
      set_lane(5, 0, 1, "R2");
      ev[5] = 1'b1; idle(1, "R2");
      ev[5] = 1'b0; idle(1, "R2");
      // R3 falling on lane 6
      ev[6] = 1'b1; set_lane(6, 1, 1, "R3");
      ev[6] = 1'b0; idle(1, "R3");
      ev[6] = 1'b1; idle(1, "R3");
      // R4 toggle on lane 7
      set_lane(7, 2, 1, "R4");
      ev[7] = 1'b1; idle(1, "R4");
      ev[7] = 1'b0; idle(1, "R4");
      // R5 reserved on lane 8
      set_lane(8, 3, 1, "R5");
      ev[8] = 1'b1; idle(1, "R5");
      ev[8] = 1'b0; idle(1, "R5");
      // R6 disabled lane 9 with toggle kind
      set_lane(9, 2, 0, "R6");
      ev[9] = 1'b1; idle(1, "R6");
      ev[9] = 1'b0; idle(1, "R6");
      // R7 held level, single pulse
      ev[5] = 1'b1; idle(3, "R7");
      ev[5] = 1'b0; idle(1, "R7");
      // R10 pointer out of range: lane 0 and lane 63 untouched
      set_lane(63, 2, 1, "R10");
      wr(3'd0, 64, "R10"); wr(3'd2, 0, "R10"); wr(3'd1, 3, "R10");
      wr(3'd0, 300, "R10"); wr(3'd2, 0, "R10");
      ev[0] = 1'b1; ev[63] = 1'b1; idle(1, "R10");
      ev[63] = 1'b0; idle(1, "R10");
      // R9: unused op codes change nothing
      wr(3'd5, 32'hFFFF_FFFF, "R9"); wr(3'd7, 0, "R9");
      ev[63] = 1'b1; idle(1, "R9");
      // R11 trigger match and near miss
      wr(3'd3, 32'h0000_00A5, "R11"); wr(3'd4, 32'h0000_00FF, "R11");
      ev[31:0] = 32'h1234_56A5; idle(1, "R11");
      ev[31:0] = 32'h1234_56A4; idle(1, "R11");
      ev[31:0] = 32'hFFFF_FFA5; idle(2, "R11");
      // R12 empty mask never triggers
      wr(3'd4, 0, "R12");
      ev[31:0] = 32'h0000_00A5; idle(2, "R12");
      ev[31:0] = '0; idle(1, "R12");

      // constrained random mix
      for (int n = 0; n < 3000; n++) begin
         logic [L-1:0] flip;
         flip = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
         ev = ev ^ flip;
         if ($urandom % 3 == 0) begin
            int o;
            logic [31:0] d;
            o = $urandom % 8;
            d = (o == 0) ? ($urandom % 80) : $urandom;
            if (o == 4) d = d & 32'h0000_F00F;
            if (o == 3) d = (d & 32'h0000_F00F) | (ev[31:0] & 32'hFFFF_0FF0);
            cyc(ev, 1, 3'(o), d, "RND");
         end else begin
            cyc(ev, 0, 0, 0, "RND");
         end
      end

      // R8 again: mid-run reset with lanes high after enabling toggles
      set_lane(3, 2, 1, "R8");
      do_reset('1);
      cyc(ev, 1, 3'd2, 1, "R8");
      ev[0] = 1'b0; idle(1, "R8");

      fin = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule